// File: doc/BRIEF.md
# Four-Level Nested Interrupt Prioritizer

This block decides which of six interrupt sources should be presented to the processor next. Each source has a request line, an individual enable and a two-bit level. The level's upper bit comes from a "high" priority vector and its lower bit from a "low" priority vector, which gives four levels (3 is the most urgent). A global enable gates every source.

The controller keeps a one-hot set with one bit per level for the levels currently in service. A request is issued only when its level is strictly above the highest level in that set, or when the set is empty. This is how a more urgent interrupt preempts a less urgent one, while an equal or lower one waits. When the processor accepts the presented request it pulses an acknowledge, which marks that level in service. A return pulse removes the highest level in service, so the preempted handler's level becomes the ceiling again.

The processor pipeline and the vector address table lie outside this block. The controller only reports the winning source index, its level and a request strobe.

Top module: `irq_nest_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, the request strobe is low and the in-service set is empty.
- R2: The level of source n is {prio_hi_i[n], prio_lo_i[n]}, with the high vector as the most significant bit.
- R3: A source takes part in arbitration only when its request, its enable bit and the global enable are all 1. With the global enable at 0 no request is issued.
- R4: Among taking-part sources the one with the highest level wins, and irq_vec_o / irq_lvl_o give its index and level.
- R5: Among winners of equal level the lowest index wins. Index order: 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 timer 2.
- R6: The winner is issued only if the in-service set is empty or the winner's level is strictly above the highest level in the set. Otherwise the request strobe stays low.
- R7: A waiting request whose level is above the highest in-service level is issued, which preempts the handler in service.
- R8: An acknowledge while the request strobe is high sets bit irq_lvl_o of the in-service set (bit k stands for level k).
- R9: A return clears the highest set bit of the in-service set. A request held by that level is then issued.
- R10: Every output is registered. The strobe, index, level and set reflect the inputs and pulses seen at one rising edge, just after that edge.
- R11: An acknowledge while the strobe is low, or a return while the set is empty, leaves the in-service set unchanged.
- R12: When acknowledge and return arrive at the same edge, the return clears first and the acknowledged level is then set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 6 | Pending request per source |
| glob_en_i | input | 1 | Global interrupt enable |
| src_en_i | input | 6 | Per-source enable |
| prio_lo_i | input | 6 | Low bit of each source's level |
| prio_hi_i | input | 6 | High bit of each source's level |
| ack_i | input | 1 | Processor accepted the presented request |
| reti_i | input | 1 | Processor returned from the current handler |
| irq_req_o | output | 1 | Request strobe to the processor |
| irq_vec_o | output | 3 | Index of the presented source |
| irq_lvl_o | output | 2 | Level of the presented source |
| in_service_o | output | 4 | One-hot set of levels in service |

## Verification
Every result is due exactly one rising edge after the stimulus that causes it. This holds for the strobe, index and level after any input change, for the set after an acknowledge or a return, and for a newly admitted request after a return lowers the ceiling, because arbitration already sees the set as it will stand after that edge. The bench drives every input on a falling edge. It updates its own model of the set and of the expected outputs for the coming rising edge, and compares at the next falling edge, so each check lands on the first cycle in which the answer is due. Random sweeps cover the input space, with the set held empty, then pinned at each single level, then with random acknowledges and returns. Directed sequences cover the four-deep nest, its unwinding, coincident pulses and ties.

// File: rtl/irq_nest_pkg.sv
// Package: shared defaults and source naming for the nested interrupt
// prioritizer. Assumes the source index order below is the tie-break order.
package irq_nest_pkg;
    localparam int IRQ_SRC_DEFAULT = 6;
    localparam int IRQ_LVL_DEFAULT = 4;

    // Source indices; a lower value wins a tie at equal level.
    typedef enum logic [2:0] {
        SRC_EXT0 = 3'd0,
        SRC_TMR0 = 3'd1,
        SRC_EXT1 = 3'd2,
        SRC_TMR1 = 3'd3,
        SRC_SER  = 3'd4,
        SRC_TMR2 = 3'd5
    } irq_src_e;
endpackage

// File: rtl/irq_level_map.sv
// Module: irq_level_map
// Gates each source's request with its own and the global enable, and forms
// each source's level from its high and low priority bits (high bit is MSB).
// Assumes LVL_W >= 2; wider levels are zero-extended.
module irq_level_map #(
    parameter int NUM_SRC = 6,
    parameter int LVL_W   = 2
) (
    input  logic [NUM_SRC-1:0]       req_i,
    input  logic [NUM_SRC-1:0]       src_en_i,
    input  logic [NUM_SRC-1:0]       prio_lo_i,
    input  logic [NUM_SRC-1:0]       prio_hi_i,
    input  logic                     glob_en_i,
    output logic [NUM_SRC-1:0]       pend_o,
    output logic [NUM_SRC*LVL_W-1:0] lvl_o
);
    // One gate and one level field per source.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign pend_o[g]                = req_i[g] & src_en_i[g] & glob_en_i;
        assign lvl_o[g*LVL_W +: LVL_W]  = LVL_W'({prio_hi_i[g], prio_lo_i[g]});
    end
endmodule

// File: rtl/irq_arbiter.sv
// Module: irq_arbiter
// Picks the pending source of highest level (lowest index on ties) and
// admits it only if it exceeds the in-service ceiling. Purely combinational.
// Assumes thr_lvl_i is meaningful only when thr_any_i is high.
module irq_arbiter #(
    parameter int NUM_SRC = 6,
    parameter int LVL_W   = 2,
    parameter int IDX_W   = 3
) (
    input  logic [NUM_SRC-1:0]       pend_i,
    input  logic [NUM_SRC*LVL_W-1:0] lvl_i,
    input  logic                     thr_any_i,
    input  logic [LVL_W-1:0]         thr_lvl_i,
    output logic                     win_valid_o,
    output logic [IDX_W-1:0]         win_idx_o,
    output logic [LVL_W-1:0]         win_lvl_o
);
    logic             best_v;
    logic [IDX_W-1:0] best_i;
    logic [LVL_W-1:0] best_l;

    // Scan from the top index down so that ">=" leaves the lowest index on ties.
    always_comb begin
        best_v = 1'b0;
        best_i = '0;
        best_l = '0;
        for (int s = NUM_SRC - 1; s >= 0; s--) begin
            if (pend_i[s] && (!best_v || lvl_i[s*LVL_W +: LVL_W] >= best_l)) begin
                best_v = 1'b1;
                best_i = IDX_W'(s);
                best_l = lvl_i[s*LVL_W +: LVL_W];
            end
        end
    end

    // Admit the winner only above the ceiling of levels in service.
    always_comb begin
        win_valid_o = best_v && (!thr_any_i || (best_l > thr_lvl_i));
        win_idx_o   = best_i;
        win_lvl_o   = best_l;
    end
endmodule

// File: rtl/irq_inservice_stack.sv
// Module: irq_inservice_stack
// Holds the one-hot set of levels in service. A pop clears the highest set
// bit, then a push sets the pushed level. Also reports the top of the set as
// it will stand after the coming edge, so arbitration never sees a stale set.
module irq_inservice_stack #(
    parameter int NUM_LVL = 4,
    parameter int LVL_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_i,
    input  logic [LVL_W-1:0]   push_lvl_i,
    input  logic               pop_i,
    output logic [NUM_LVL-1:0] set_o,
    output logic               nxt_any_o,
    output logic [LVL_W-1:0]   nxt_top_o
);
    logic [NUM_LVL-1:0] set_q;
    logic [NUM_LVL-1:0] popped;
    logic [NUM_LVL-1:0] set_d;
    logic [LVL_W-1:0]   cur_top;
    logic               cur_any;

    // Highest set bit of the current set.
    always_comb begin
        cur_any = 1'b0;
        cur_top = '0;
        for (int i = 0; i < NUM_LVL; i++) begin
            if (set_q[i]) begin
                cur_any = 1'b1;
                cur_top = LVL_W'(i);
            end
        end
    end

    // Next set: pop first, then push.
    always_comb begin
        popped = set_q;
        if (pop_i && cur_any) begin
            popped[cur_top] = 1'b0;
        end
        set_d = popped | (push_i ? (NUM_LVL'(1) << push_lvl_i) : '0);
    end

    // Highest set bit of the next set, used as the arbitration ceiling.
    always_comb begin
        nxt_any_o = 1'b0;
        nxt_top_o = '0;
        for (int i = 0; i < NUM_LVL; i++) begin
            if (set_d[i]) begin
                nxt_any_o = 1'b1;
                nxt_top_o = LVL_W'(i);
            end
        end
    end

    // Set register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_q <= '0;
        end else begin
            set_q <= set_d;
        end
    end

    assign set_o = set_q;
endmodule

// File: rtl/irq_nest_ctrl.sv
// Module: irq_nest_ctrl (top)
// Four-level nested interrupt prioritizer for six sources. It registers the
// admitted winner as a request strobe with index and level. An acknowledge
// pushes the presented level into the in-service set and a return pops the
// highest. Assumes the processor acknowledges only a strobe it has seen and
// clears a source's request itself.
module irq_nest_ctrl #(
    parameter  int NUM_SRC = irq_nest_pkg::IRQ_SRC_DEFAULT,
    parameter  int NUM_LVL = irq_nest_pkg::IRQ_LVL_DEFAULT,
    localparam int LVL_W   = $clog2(NUM_LVL),
    localparam int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic               glob_en_i,
    input  logic [NUM_SRC-1:0] src_en_i,
    input  logic [NUM_SRC-1:0] prio_lo_i,
    input  logic [NUM_SRC-1:0] prio_hi_i,
    input  logic               ack_i,
    input  logic               reti_i,
    output logic               irq_req_o,
    output logic [IDX_W-1:0]   irq_vec_o,
    output logic [LVL_W-1:0]   irq_lvl_o,
    output logic [NUM_LVL-1:0] in_service_o
);
    logic [NUM_SRC-1:0]       pend;
    logic [NUM_SRC*LVL_W-1:0] lvl_flat;
    logic                     thr_any;
    logic [LVL_W-1:0]         thr_lvl;
    logic                     win_valid;
    logic [IDX_W-1:0]         win_idx;
    logic [LVL_W-1:0]         win_lvl;
    logic                     req_q;
    logic [IDX_W-1:0]         vec_q;
    logic [LVL_W-1:0]         lvl_q;
    logic                     accept;

    // An acknowledge counts only against a presented request.
    assign accept = ack_i & req_q;

    irq_level_map #(
        .NUM_SRC (NUM_SRC),
        .LVL_W   (LVL_W)
    ) u_map (
        .req_i     (req_i),
        .src_en_i  (src_en_i),
        .prio_lo_i (prio_lo_i),
        .prio_hi_i (prio_hi_i),
        .glob_en_i (glob_en_i),
        .pend_o    (pend),
        .lvl_o     (lvl_flat)
    );

    irq_inservice_stack #(
        .NUM_LVL (NUM_LVL),
        .LVL_W   (LVL_W)
    ) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (accept),
        .push_lvl_i (lvl_q),
        .pop_i      (reti_i),
        .set_o      (in_service_o),
        .nxt_any_o  (thr_any),
        .nxt_top_o  (thr_lvl)
    );

    irq_arbiter #(
        .NUM_SRC (NUM_SRC),
        .LVL_W   (LVL_W),
        .IDX_W   (IDX_W)
    ) u_arb (
        .pend_i      (pend),
        .lvl_i       (lvl_flat),
        .thr_any_i   (thr_any),
        .thr_lvl_i   (thr_lvl),
        .win_valid_o (win_valid),
        .win_idx_o   (win_idx),
        .win_lvl_o   (win_lvl)
    );

    // Output registers for strobe, index and level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            vec_q <= '0;
            lvl_q <= '0;
        end else begin
            req_q <= win_valid;
            vec_q <= win_idx;
            lvl_q <= win_lvl;
        end
    end

    assign irq_req_o = req_q;
    assign irq_vec_o = vec_q;
    assign irq_lvl_o = lvl_q;
endmodule

// File: rtl/irq_nest_chk.sv
// Module: irq_nest_chk
// Property checker for irq_nest_ctrl, attached by the bind below. Observes
// ports only and derives the top of the in-service set on its own.
module irq_nest_chk #(
    parameter  int NUM_SRC = 6,
    parameter  int NUM_LVL = 4,
    localparam int LVL_W   = $clog2(NUM_LVL),
    localparam int IDX_W   = $clog2(NUM_SRC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               glob_en_i,
    input logic               ack_i,
    input logic               reti_i,
    input logic               irq_req_o,
    input logic [IDX_W-1:0]   irq_vec_o,
    input logic [LVL_W-1:0]   irq_lvl_o,
    input logic [NUM_LVL-1:0] in_service_o
);
    logic             chk_any;
    logic [LVL_W-1:0] chk_top;

    // Highest level currently in service, as seen at the ports.
    always_comb begin
        chk_any = 1'b0;
        chk_top = '0;
        for (int i = 0; i < NUM_LVL; i++) begin
            if (in_service_o[i]) begin
                chk_any = 1'b1;
                chk_top = LVL_W'(i);
            end
        end
    end

    AST_ABOVE_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> (!chk_any || (irq_lvl_o > chk_top)));                         // R6
    AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en_i |=> !irq_req_o);                                                 // R3
    AST_ACK_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_req_o && !reti_i) |=>
        (in_service_o == ($past(in_service_o) | (NUM_LVL'(1) << $past(irq_lvl_o))))); // R8
    AST_RETI_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && !ack_i && (in_service_o != '0)) |=>
        ($countones(in_service_o) + 1 == $countones($past(in_service_o))));          // R9
    AST_SET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!reti_i && !(ack_i && irq_req_o)) |=> $stable(in_service_o));               // R11
    AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> (int'(irq_vec_o) < NUM_SRC));                                  // R4
endmodule

bind irq_nest_ctrl irq_nest_chk #(
    .NUM_SRC (NUM_SRC),
    .NUM_LVL (NUM_LVL)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .glob_en_i    (glob_en_i),
    .ack_i        (ack_i),
    .reti_i       (reti_i),
    .irq_req_o    (irq_req_o),
    .irq_vec_o    (irq_vec_o),
    .irq_lvl_o    (irq_lvl_o),
    .in_service_o (in_service_o)
);

// File: tb/sim_irq_nest_ctrl.sv
`timescale 1ns/1ps
module sim_irq_nest_ctrl;
    localparam int CLK_HALF = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] rq = '0, en = '0, lo = '0, hi = '0;
    logic       g = 1'b0, ack = 1'b0, reti = 1'b0;
    logic       irq_req;
    logic [2:0] irq_vec;
    logic [1:0] irq_lvl;
    logic [3:0] in_svc;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic       e_req = 1'b0;
    logic [2:0] e_vec = '0;
    logic [1:0] e_lvl = '0;
    logic [3:0] e_set = '0;
    logic [31:0] x = 32'h1234_5678;

    always #CLK_HALF clk = ~clk;

    irq_nest_ctrl u0 (
        .clk (clk), .rst_n (rst_n), .req_i (rq), .glob_en_i (g),
        .src_en_i (en), .prio_lo_i (lo), .prio_hi_i (hi),
        .ack_i (ack), .reti_i (reti), .irq_req_o (irq_req),
        .irq_vec_o (irq_vec), .irq_lvl_o (irq_lvl), .in_service_o (in_svc)
    );

    task automatic check_eq(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected {valid, index, level} from the stated rules.
    function automatic logic [5:0] model_arb(input logic [3:0] set);
        int best = -1;
        int bi = 0;
        int top = -1;
        for (int s = 0; s < 6; s++) begin
            if (g && rq[s] && en[s]) begin
                int l = 2 * int'(hi[s]) + int'(lo[s]);
                if (l > best) begin best = l; bi = s; end
            end
        end
        for (int i = 0; i < 4; i++) if (set[i]) top = i;
        return {(best >= 0) && (best > top), 3'(bi), 2'(best < 0 ? 0 : best)};
    endfunction

    // One clock: predict the coming edge, let it pass, compare at the falling edge.
    task automatic step(string tag);
        logic [3:0] ns = e_set;
        logic [5:0] r;
        if (reti) begin
            for (int i = 3; i >= 0; i--) if (ns[i]) begin ns[i] = 1'b0; break; end
        end
        if (ack && e_req) ns[e_lvl] = 1'b1;
        r = model_arb(ns);
        @(posedge clk);
        e_set = ns; e_req = r[5]; e_vec = r[4:2]; e_lvl = r[1:0];
        @(negedge clk);
        check_eq({tag, " R10 strobe"}, int'(irq_req), int'(e_req));
        check_eq({tag, " R8 set"}, int'(in_svc), int'(e_set));
        if (e_req) begin
            check_eq({tag, " R4 index"}, int'(irq_vec), int'(e_vec));
            check_eq({tag, " R2 level"}, int'(irq_lvl), int'(e_lvl));
        end
    endtask

    task automatic rnd();
        x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    endtask

    task automatic rnd_inputs();
        rnd(); rq = x[5:0]; en = x[11:6] | x[17:12]; lo = x[23:18]; hi = x[29:24];
        rnd(); g = (x[2:0] != 3'd0);
    endtask

    initial begin
        #(2 * CLK_HALF * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        @(negedge clk); @(negedge clk);
        check_eq("R1 strobe in reset", int'(irq_req), 0);
        check_eq("R1 set in reset", int'(in_svc), 0);
        rst_n = 1'b1;
        step("R1 first cycle");

        // Sweep with nothing in service: R2 R3 R4 R5
        for (int n = 0; n < 400; n++) begin
            rnd_inputs();
            step("sweep empty R3 R5");
        end

        // Sweep with each single level in service: R6 R7
        for (int t = 0; t < 4; t++) begin
            rq = 6'b000001; en = '1; g = 1'b1;
            lo = {5'b0, t[0]}; hi = {5'b0, t[1]};
            step("pin level");
            ack = 1'b1; step("pin ack R8"); ack = 1'b0;
            check_eq("R8 single level set", int'(in_svc), 1 << t);
            for (int n = 0; n < 80; n++) begin
                rnd_inputs();
                step("sweep ceiling R6 R7");
            end
            reti = 1'b1; step("unpin R9"); reti = 1'b0;
        end

        // Directed four-deep nest: source k at level k, source 4 at level 1
        rq = '0; en = '1; g = 1'b1; hi = 6'b001100; lo = 6'b011010;
        step("idle");
        rq = 6'b000001; step("R10 level0");
        check_eq("R10 vec after one edge", int'(irq_vec), 0);
        ack = 1'b1; step("ack0"); ack = 1'b0;
        check_eq("R6 same level held", int'(irq_req), 0);
        rq = 6'b000011; step("R7 level1");
        check_eq("R7 preempt vec", int'(irq_vec), 1);
        ack = 1'b1; step("ack1"); ack = 1'b0;
        rq = 6'b010011; step("R6 equal level held");
        check_eq("R6 equal level strobe", int'(irq_req), 0);
        rq = 6'b010111; step("level2");
        ack = 1'b1; step("ack2"); ack = 1'b0;
        rq = 6'b011111; step("level3");
        check_eq("R7 vec3", int'(irq_vec), 3);
        ack = 1'b1; step("ack3"); ack = 1'b0;
        check_eq("R8 full nest", int'(in_svc), 4'b1111);
        rq = 6'b010000;
        reti = 1'b1; step("pop3");
        check_eq("R9 pop to 0111", int'(in_svc), 4'b0111);
        step("pop2"); step("pop1");
        reti = 1'b0;
        check_eq("R9 pop to 0001", int'(in_svc), 4'b0001);
        check_eq("R9 resumed strobe", int'(irq_req), 1);
        check_eq("R9 resumed vec", int'(irq_vec), 4);

        // R12: coincident acknowledge and return
        ack = 1'b1; reti = 1'b1; step("R12 both"); ack = 1'b0; reti = 1'b0;
        check_eq("R12 set", int'(in_svc), 4'b0010);

        // R11: ignored pulses
        rq = '0; reti = 1'b1; step("R11 pop last"); reti = 1'b0;
        ack = 1'b1; step("R11 ack no strobe"); ack = 1'b0;
        check_eq("R11 ack ignored", int'(in_svc), 0);
        reti = 1'b1; step("R11 pop empty"); reti = 1'b0;
        check_eq("R11 pop empty", int'(in_svc), 0);

        // R5 tie and R3 gating
        hi = 6'b111111; lo = 6'b000000; rq = 6'b110110;
        step("R5 tie");
        check_eq("R5 tie lowest index", int'(irq_vec), 1);
        g = 1'b0; step("R3 global off");
        check_eq("R3 global off", int'(irq_req), 0);
        g = 1'b1; en = 6'b111101; step("R3 source off");
        check_eq("R3 source off", int'(irq_vec), 2);

        // Random nesting with acknowledges and returns: R7 R8 R9 R11 R12
        for (int n = 0; n < 1200; n++) begin
            rnd_inputs();
            rnd(); ack = (x[1:0] == 2'd0); reti = (x[4:2] == 3'd0);
            step("random nest R12");
        end
        ack = 1'b0; reti = 1'b0;

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule